// File: doc/BRIEF.md
# Strobed Bidirectional Port Pair

This block provides two general-purpose parallel ports, A and B, that sit behind a small register read/write interface. A single control register sets, for each port, whether it drives or listens, whether a driven 1 is pushed high or only released (open-drain), and whether capturing new input data should raise the interrupt request. Each port has one strobe pin. The strobe pin changes role with the port's direction.

When a port listens, a falling edge on its strobe pin captures the port pins into that port's data register. The strobe pin first passes through a two-flop synchronizer. The capture also sets a per-port "new data" flag. Reading the port's data register clears that flag. The interrupt request is modelled as an open-drain pull-down enable.

When a port drives, each write to its data register updates the pins. Each such write also emits a fixed-length high pulse on the strobe pin. The pins then hold their value until the next write.

The reset pin has a configurable active level. A separate power-on reset clears everything, including the level selection.

Top module: `strobed_port_pair`

## Requirements
- R1: The control register sits at address 0 and reads back as written. Its bits are: 0 = port A drives, 1 = port A open-drain, 2 = port A interrupt enable, 3 = port B drives, 4 = port B open-drain, 5 = port B interrupt enable, 7 = reset pin active high. Bit 6 reads 0.
- R2: Port A data is at address 1 and port B data at address 2. Address 3 reads 0. In push-pull drive mode, the pins carry the data register and every pin enable is 1. When a port listens, all its pin enables and its strobe enable are 0.
- R3: In open-drain drive mode, the pin output value is 0 and each pin enable is the inverse of the corresponding data bit.
- R4: Each write to a driving port's data register makes its strobe output high for exactly PULSE_LEN (default 4) cycles, starting the cycle after the write. A write that arrives during a pulse restarts the full pulse.
- R5: A driving port's data register and pins change only on a write to it. A write to a listening port's data register has no effect.
- R6: On a listening port, a falling strobe edge captures the port pins into the data register, which can be read back 3 cycles after the edge. Rising edges are ignored. Strobe edges on a driving port are ignored.
- R7: A capture sets the port's new-data flag. The interrupt pull-down enable is 1 while any port has both its flag and its interrupt enable set, and 0 when the enable is clear.
- R8: Reading a port's data register clears that port's new-data flag. A capture in the same cycle wins over the clear.
- R9: The reset pin is active low by default. With control bit 7 set, it is active high instead. It clears control bits 0 to 5, the data registers, the flags and the pulses, and keeps bit 7.
- R10: The power-on reset clears all state, including bit 7. After any reset, no pin or strobe is driven and the interrupt is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_pin | input | 1 | Reset pin with configurable active level |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| pa_in | input | 8 | Port A pin input values |
| pa_out | output | 8 | Port A pin output values |
| pa_oe | output | 8 | Port A per-pin drive enables |
| stba_in | input | 1 | Port A strobe pin input |
| stba_out | output | 1 | Port A strobe pin output |
| stba_oe | output | 1 | Port A strobe drive enable |
| pb_in | input | 8 | Port B pin input values |
| pb_out | output | 8 | Port B pin output values |
| pb_oe | output | 8 | Port B per-pin drive enables |
| stbb_in | input | 1 | Port B strobe pin input |
| stbb_out | output | 1 | Port B strobe pin output |
| stbb_oe | output | 1 | Port B strobe drive enable |
| irq_oe | output | 1 | Interrupt pull-down enable (open-drain) |

## Verification
The assertions check on every cycle that:
- a write to a driving port starts a pulse and loads its data;
- a driving port's data never changes without a write;
- a detected falling edge loads the pins;
- a read clears the flag unless a capture coincides;
- a newly raised, enabled flag pulls the interrupt line.

Only the bench's scenarios show the rest:
- the exact pulse length and its restart;
- the three-cycle capture latency;
- the open-drain pin mapping;
- the fact that writes to listening ports and edges on driving ports change nothing;
- the swap of the reset pin's active level followed by recovery through power-on reset.

// File: rtl/spp_pkg.sv
package spp_pkg;
   typedef struct packed {
      logic       rst_hi;
      logic       rsvd;
      logic       ie_b;
      logic       od_b;
      logic       drv_b;
      logic       ie_a;
      logic       od_a;
      logic       drv_a;
   } spp_ctrl_t;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_PA   = 2'd1;
   localparam logic [1:0] ADDR_PB   = 2'd2;
endpackage

// File: rtl/spp_fall_sync.sv
module spp_fall_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic srst,
   input  logic async_in,
   output logic fall
);
   if (STAGES < 2) begin : g_bad
      $error("spp_fall_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      chain_q <= '1;
      else if (srst)   chain_q <= '1;
      else             chain_q <= {chain_q[STAGES-1:0], async_in};
   end

   // chain_q[STAGES-1] is the last synchronizer flop, chain_q[STAGES] the edge register
   assign fall = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/spp_port.sv
module spp_port #(
   parameter int WIDTH     = 8,
   parameter int PULSE_LEN = 4,
   parameter int SYNC_FF   = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             srst,
   input  logic             drive,
   input  logic             od,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd_clr,
   input  logic [WIDTH-1:0] pin_in,
   input  logic             stb_in,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe,
   output logic             stb_out,
   output logic             stb_oe,
   output logic [WIDTH-1:0] data_q,
   output logic             flag_q
);
   localparam int CNT_W = $clog2(PULSE_LEN + 1);

   if (WIDTH < 1 || PULSE_LEN < 1) begin : g_bad
      $error("spp_port: WIDTH and PULSE_LEN must be positive");
   end

   logic             fall;
   logic             capture;
   logic [CNT_W-1:0] cnt_q;

   spp_fall_sync #(.STAGES(SYNC_FF)) sync_i (
      .clk(clk), .por_n(por_n), .srst(srst), .async_in(stb_in), .fall(fall)
   );

   assign capture = fall & ~drive;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         data_q <= '0;
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else if (srst) begin
         data_q <= '0;
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (drive && wr_en) begin
            data_q <= wdata;
            cnt_q  <= CNT_W'(PULSE_LEN);
         end else begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            if (capture)     data_q <= pin_in;
         end
         if (capture)     flag_q <= 1'b1;
         else if (rd_clr) flag_q <= 1'b0;
      end
   end

   assign stb_out = (cnt_q != '0);
   assign stb_oe  = drive;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         if (!drive) begin
            pin_out[i] = 1'b0;
            pin_oe[i]  = 1'b0;
         end else if (od) begin
            pin_out[i] = 1'b0;
            pin_oe[i]  = ~data_q[i];
         end else begin
            pin_out[i] = data_q[i];
            pin_oe[i]  = 1'b1;
         end
      end
   end

   // R4
   pulse_start_chk: assert property (@(posedge clk) disable iff (!por_n || srst)
      (drive && wr_en) |=> (stb_out && data_q == $past(wdata)));

   // R5
   hold_data_chk: assert property (@(posedge clk) disable iff (!por_n || srst)
      (drive && !wr_en) |=> $stable(data_q));

   // R6
   capture_chk: assert property (@(posedge clk) disable iff (!por_n || srst)
      (fall && !drive) |=> (data_q == $past(pin_in) && flag_q));

   // R8
   read_clear_chk: assert property (@(posedge clk) disable iff (!por_n || srst)
      (rd_clr && !(fall && !drive)) |=> !flag_q);
endmodule

// File: rtl/strobed_port_pair.sv
module strobed_port_pair
   import spp_pkg::*;
#(
   parameter int PORT_W    = 8,
   parameter int PULSE_LEN = 4,
   parameter int SYNC_FF   = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_pin,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic [PORT_W-1:0] pa_in,
   output logic [PORT_W-1:0] pa_out,
   output logic [PORT_W-1:0] pa_oe,
   input  logic              stba_in,
   output logic              stba_out,
   output logic              stba_oe,
   input  logic [PORT_W-1:0] pb_in,
   output logic [PORT_W-1:0] pb_out,
   output logic [PORT_W-1:0] pb_oe,
   input  logic              stbb_in,
   output logic              stbb_out,
   output logic              stbb_oe,
   output logic              irq_oe
);
   if (PORT_W < 1 || PORT_W > 8) begin : g_bad
      $error("strobed_port_pair: PORT_W must be 1..8");
   end

   spp_ctrl_t         ctrl_q;
   logic              srst;
   logic [PORT_W-1:0] data_a, data_b;
   logic              flag_a, flag_b;

   assign srst = ctrl_q.rst_hi ? rst_pin : ~rst_pin;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ctrl_q <= '0;
      end else if (srst) begin
         ctrl_q <= '{rst_hi: ctrl_q.rst_hi, default: 1'b0};
      end else if (reg_wr && reg_addr == ADDR_CTRL) begin
         ctrl_q      <= spp_ctrl_t'(reg_wdata);
         ctrl_q.rsvd <= 1'b0;
      end
   end

   spp_port #(.WIDTH(PORT_W), .PULSE_LEN(PULSE_LEN), .SYNC_FF(SYNC_FF)) port_a_i (
      .clk(clk), .por_n(por_n), .srst(srst),
      .drive(ctrl_q.drv_a), .od(ctrl_q.od_a),
      .wr_en(reg_wr && reg_addr == ADDR_PA), .wdata(reg_wdata[PORT_W-1:0]),
      .rd_clr(reg_rd && reg_addr == ADDR_PA),
      .pin_in(pa_in), .stb_in(stba_in),
      .pin_out(pa_out), .pin_oe(pa_oe), .stb_out(stba_out), .stb_oe(stba_oe),
      .data_q(data_a), .flag_q(flag_a)
   );

   spp_port #(.WIDTH(PORT_W), .PULSE_LEN(PULSE_LEN), .SYNC_FF(SYNC_FF)) port_b_i (
      .clk(clk), .por_n(por_n), .srst(srst),
      .drive(ctrl_q.drv_b), .od(ctrl_q.od_b),
      .wr_en(reg_wr && reg_addr == ADDR_PB), .wdata(reg_wdata[PORT_W-1:0]),
      .rd_clr(reg_rd && reg_addr == ADDR_PB),
      .pin_in(pb_in), .stb_in(stbb_in),
      .pin_out(pb_out), .pin_oe(pb_oe), .stb_out(stbb_out), .stb_oe(stbb_oe),
      .data_q(data_b), .flag_q(flag_b)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_CTRL: reg_rdata = ctrl_q;
         ADDR_PA:   reg_rdata[PORT_W-1:0] = data_a;
         ADDR_PB:   reg_rdata[PORT_W-1:0] = data_b;
         default:   reg_rdata = '0;
      endcase
   end

   assign irq_oe = (flag_a & ctrl_q.ie_a) | (flag_b & ctrl_q.ie_b);

   // R7
   irq_raise_chk: assert property (@(posedge clk) disable iff (!por_n || srst)
      (($rose(flag_a) && ctrl_q.ie_a) || ($rose(flag_b) && ctrl_q.ie_b)) |-> irq_oe);

   // R9
   keep_pol_chk: assert property (@(posedge clk) disable iff (!por_n)
      (srst && !(reg_wr && reg_addr == ADDR_CTRL)) |=> $stable(ctrl_q.rst_hi));
endmodule

// File: tb/strobed_port_pair_tb_top.sv
module strobed_port_pair_tb_top;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       rst_pin = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic [7:0] pa_in = '0, pa_out, pa_oe, pb_in = '0, pb_out, pb_oe;
   logic       stba_in = 1'b1, stba_out, stba_oe, stbb_in = 1'b1, stbb_out, stbb_oe;
   logic       irq_oe;

   int tests = 0, fails = 0;

   always #2.5 clk = ~clk;

   strobed_port_pair dut_i (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_out(input logic [7:0] d, input logic drv, input logic od);
      return (drv && !od) ? d : 8'h00;
   endfunction
   function automatic logic [7:0] exp_oe(input logic [7:0] d, input logic drv, input logic od);
      return !drv ? 8'h00 : (od ? ~d : 8'hFF);
   endfunction

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1; #1;
      d = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; #1;
      d = reg_rdata;
   endtask

   task automatic pulse_len(input string req, input int exp_len);
      int n = 0;
      for (int i = 0; i < exp_len + 3; i++) begin
         @(negedge clk);
         if (stba_out) n++;
      end
      check(req, n, exp_len);
   endtask

   task automatic strobe_a(input logic [7:0] v);
      @(negedge clk);
      pa_in = v; stba_in = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      stba_in = 1'b1;
      repeat (4) @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [7:0] r, v, w;
      logic od;
      void'($urandom(32'h5EED));
      rst_pin = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); por_n = 1'b1;
      repeat (2) @(posedge clk);

      // R10 reset state
      peek(2'd0, r); check("R10 ctrl", r, 8'h00);
      check("R10 oe", {pa_oe, pb_oe, 6'b0, stba_oe, stbb_oe, 6'b0, irq_oe}, 32'h0);

      // R1 control readback, reserved bit
      wr(2'd0, 8'h7F); peek(2'd0, r); check("R1 ctrl", r, 8'h3F);
      peek(2'd3, r); check("R2 addr3", r, 8'h00);

      // R2 / R3 / R4 random drive patterns on port A
      for (int k = 0; k < 20; k++) begin
         od = 1'($urandom);
         v  = 8'($urandom);
         wr(2'd0, {6'b0, od, 1'b1});
         wr(2'd1, v);
         @(negedge clk);
         check(od ? "R3 out" : "R2 out", pa_out, exp_out(v, 1'b1, od));
         check(od ? "R3 oe" : "R2 oe", pa_oe, exp_oe(v, 1'b1, od));
      end

      // R4 pulse length after a quiet period
      repeat (8) @(posedge clk);
      wr(2'd1, 8'hA5); pulse_len("R4 len", 4);
      // R4 restart
      wr(2'd1, 8'h11);
      @(negedge clk); @(negedge clk);
      wr(2'd1, 8'h22); pulse_len("R4 restart", 4);

      // R5 stable without writes; strobe edge on driving port ignored (R6)
      @(negedge clk); stba_in = 1'b0; pa_in = 8'h3C;
      repeat (6) @(posedge clk);
      @(negedge clk); stba_in = 1'b1;
      peek(2'd1, r); check("R5 hold", r, 8'h22);
      check("R6 drive ignore", pa_out, 8'h22);
      check("R7 no flag", irq_oe, 1'b0);

      // R2 listening mode releases pins; R5 write ignored
      wr(2'd0, 8'h04);
      @(negedge clk); check("R2 listen oe", {pa_oe, 7'b0, stba_oe}, 16'h0);
      wr(2'd1, 8'hEE); peek(2'd1, r); check("R5 ignore wr", r, 8'h22);

      // R6 / R7 / R8 random captures
      for (int k = 0; k < 10; k++) begin
         v = 8'($urandom);
         strobe_a(v);
         peek(2'd1, r); check("R6 capture", r, v);
         check("R7 irq", irq_oe, 1'b1);
         rd(2'd1, r);
         @(negedge clk); check("R8 clear", irq_oe, 1'b0);
      end

      // R6 capture latency: visible exactly 3 edges after the fall
      @(negedge clk); pa_in = 8'h5A; stba_in = 1'b0;
      repeat (2) @(posedge clk); #1; check("R6 early", reg_rdata, r);
      @(posedge clk); #1; check("R6 latency", reg_rdata, 8'h5A);
      @(negedge clk); stba_in = 1'b1; pa_in = 8'h00;
      repeat (5) @(posedge clk);
      peek(2'd1, r); check("R6 rise ignore", r, 8'h5A);

      // R7 interrupt disabled
      wr(2'd0, 8'h00); strobe_a(8'h99);
      @(negedge clk); check("R7 masked", irq_oe, 1'b0);
      wr(2'd0, 8'h04); @(negedge clk); check("R7 enable late", irq_oe, 1'b1);
      rd(2'd1, r);

      // port B capture and drive
      wr(2'd0, 8'h00);
      @(negedge clk); pb_in = 8'hC3; stbb_in = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk); stbb_in = 1'b1;
      peek(2'd2, r); check("R6 port B", r, 8'hC3);
      wr(2'd0, 8'h18); wr(2'd2, 8'h0F);
      @(negedge clk); check("R3 port B oe", pb_oe, 8'hF0);

      // R9 reset polarity swap
      rst_pin = 1'b1;
      wr(2'd0, 8'h81);
      repeat (2) @(posedge clk);
      peek(2'd0, r); check("R9 hi active", r, 8'h80);
      peek(2'd2, r); check("R9 data clr", r, 8'h00);
      @(negedge clk); rst_pin = 1'b0;
      wr(2'd0, 8'h81); wr(2'd1, 8'h77);
      peek(2'd1, r); check("R9 low inactive", r, 8'h77);

      // R10 power-on reset clears polarity
      @(negedge clk); por_n = 1'b0;
      @(negedge clk); peek(2'd0, r); check("R10 por", r, 8'h00);
      rst_pin = 1'b1; @(negedge clk); por_n = 1'b1;
      wr(2'd0, 8'h01); peek(2'd0, r); check("R9 default", r, 8'h01);
      @(negedge clk); rst_pin = 1'b0;
      @(posedge clk); @(negedge clk);
      peek(2'd0, r); check("R9 low reset", r, 8'h00);
      check("R10 idle", {pa_oe, stba_out, irq_oe}, 10'h0);
      rst_pin = 1'b1;
      w = 0;

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule